// File: doc/BRIEF.md
# Host-Bus MIDI Mailbox Bridge

This block sits between an 8-bit ISA-style host I/O bus and a small microcontroller. The host sees two byte-wide registers, a data port and a command/status port, in a partly decoded 8-address window. A two-bit jumper places that window at 300h, 310h, 320h or 330h. Host writes to either port land in their own one-byte mailbox, and a pending flag tells the microcontroller that the mailbox holds a byte. The microcontroller clears that flag with an acknowledge pulse.

In the other direction, the microcontroller loads a message byte into an outbound mailbox. Loading it raises the host interrupt, and the interrupt stays up until the host reads the data port. A status byte tells the host whether a message is waiting and whether the bridge can take another write.

All bus inputs are sampled on the local clock. An access takes effect in the first clock cycle in which its decoded strobe is seen active. The read-data bus is combinational from the decode and the strobe.

Top module: `isa_midi_bridge`

## Requirements
- R1: The bridge is selected only when host_addr[9:8]=11, host_addr[7:6]=00, host_addr[5:4] equals jumper, and host_addr[3]=0. An access to any other address changes no flag, no mailbox and no output.
- R2: host_addr[2:1] are ignored. host_addr[0]=0 selects the data port and host_addr[0]=1 selects the command/status port, anywhere in the window.
- R3: While host_aen is high, every access is ignored: nothing is captured and the read bus is not enabled.
- R4: A host write to the data port puts host_wdata on mcu_data and sets mcu_data_pend. A host write to the command port puts host_wdata on mcu_cmd and sets mcu_cmd_pend. Each write is captured in the first cycle its strobe is active, so a data write and a command write in consecutive strobes are both kept.
- R5: A high mcu_cmd_ack clears mcu_cmd_pend, and a high mcu_data_ack clears mcu_data_pend, on the next clock. If a host write to the same port is captured in that cycle, the flag stays set and the new byte is kept.
- R6: A pulse on mcu_msg_load stores mcu_msg and sets host_irq (and mcu_msg_pend) on the next clock.
- R7: A host read of the data port returns the stored message, and host_irq and mcu_msg_pend drop one cycle after the read strobe is first seen. If mcu_msg_load is high in that same cycle, the new byte is stored and host_irq stays high.
- R8: A status read returns bit 7 = 0 when a message is pending and 1 otherwise. It returns bit 6 = 1 while mcu_cmd_pend or mcu_data_pend is set, and 0 when a new write can be accepted. Bits 5:0 always read as 1.
- R9: host_rdata_oe is high only while host_ior_n is low, host_aen is low and the address is decoded. host_rdata is 0 whenever host_rdata_oe is low.
- R10: A high rst at a clock edge clears mcu_cmd_pend, mcu_data_pend, mcu_msg_pend and host_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| jumper | input | 2 | Window select, matched against host_addr[5:4] |
| host_addr | input | 10 | Host I/O address |
| host_aen | input | 1 | DMA address enable; high means the access is ignored |
| host_ior_n | input | 1 | Host read strobe, active low |
| host_iow_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Enable for the read-data driver |
| host_irq | output | 1 | Host interrupt: a message is waiting |
| mcu_cmd | output | 8 | Last command byte written by the host |
| mcu_cmd_pend | output | 1 | Command byte not yet acknowledged |
| mcu_cmd_ack | input | 1 | Clears mcu_cmd_pend |
| mcu_data | output | 8 | Last data byte written by the host |
| mcu_data_pend | output | 1 | Data byte not yet acknowledged |
| mcu_data_ack | input | 1 | Clears mcu_data_pend |
| mcu_msg | input | 8 | Message byte for the host |
| mcu_msg_load | input | 1 | Stores mcu_msg and raises host_irq |
| mcu_msg_pend | output | 1 | Message not yet read by the host |

## Verification
A wrong pending flag shows up on the next status read as a flipped bit 7 or bit 6. It also shows on the microcontroller pins one clock after the event that should have changed it. A lost or doubled strobe edge shows as a mailbox byte that is stale, or as a flag that a back-to-back access failed to set. Bad decoding shows at once, within the same strobe: the read enable rises for a foreign address, or a write to a foreign address sets a flag one cycle later. The collision cases (acknowledge against a new write, load against a host read) are timed to the exact cycle, so a wrong priority shows in the very next sample.

// File: rtl/isa_midi_bridge.sv
module isa_midi_bridge (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] jumper,
  input  logic [9:0] host_addr,
  input  logic       host_aen,
  input  logic       host_ior_n,
  input  logic       host_iow_n,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rdata_oe,
  output logic       host_irq,
  output logic [7:0] mcu_cmd,
  output logic       mcu_cmd_pend,
  input  logic       mcu_cmd_ack,
  output logic [7:0] mcu_data,
  output logic       mcu_data_pend,
  input  logic       mcu_data_ack,
  input  logic [7:0] mcu_msg,
  input  logic       mcu_msg_load,
  output logic       mcu_msg_pend
);

  logic       hit, rd_on, wr_on, rd_was, wr_was, rd_edge, wr_edge;
  logic [7:0] msg_q, status;

  assign hit = !host_aen && host_addr[9:8] == 2'b11 && host_addr[7:6] == 2'b00 &&
               host_addr[5:4] == jumper && !host_addr[3];
  assign rd_on   = hit && !host_ior_n;
  assign wr_on   = hit && !host_iow_n;
  assign rd_edge = rd_on && !rd_was;
  assign wr_edge = wr_on && !wr_was;

  assign status        = {!mcu_msg_pend, mcu_cmd_pend || mcu_data_pend, 6'h3f};
  assign host_rdata_oe = rd_on;
  assign host_rdata    = rd_on ? (host_addr[0] ? status : msg_q) : 8'h00;
  assign host_irq      = mcu_msg_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_was        <= 1'b0;
      wr_was        <= 1'b0;
      mcu_cmd_pend  <= 1'b0;
      mcu_data_pend <= 1'b0;
      mcu_msg_pend  <= 1'b0;
    end else begin
      rd_was <= rd_on;
      wr_was <= wr_on;
      if (wr_edge && host_addr[0])       mcu_cmd_pend  <= 1'b1;
      else if (mcu_cmd_ack)              mcu_cmd_pend  <= 1'b0;
      if (wr_edge && !host_addr[0])      mcu_data_pend <= 1'b1;
      else if (mcu_data_ack)             mcu_data_pend <= 1'b0;
      if (mcu_msg_load)                  mcu_msg_pend  <= 1'b1;
      else if (rd_edge && !host_addr[0]) mcu_msg_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_edge && host_addr[0])  mcu_cmd  <= host_wdata;
    if (wr_edge && !host_addr[0]) mcu_data <= host_wdata;
    if (mcu_msg_load)             msg_q    <= mcu_msg;
  end

endmodule

// File: rtl/isa_midi_bridge_chk.sv
module isa_midi_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] jumper,
  input logic [9:0] host_addr,
  input logic       host_aen,
  input logic       host_ior_n,
  input logic       host_iow_n,
  input logic [7:0] host_rdata,
  input logic       host_rdata_oe,
  input logic       host_irq,
  input logic       mcu_cmd_pend,
  input logic       mcu_cmd_ack,
  input logic       mcu_data_pend,
  input logic       mcu_data_ack,
  input logic       mcu_msg_load,
  input logic       mcu_msg_pend
);

  assert_oe_needs_strobe_R9: assert property (@(posedge clk)
    host_rdata_oe |-> (!host_ior_n && !host_aen && host_addr[9:8] == 2'b11 && !host_addr[3]));

  assert_aen_blocks_read_R3: assert property (@(posedge clk) host_aen |-> !host_rdata_oe);

  assert_status_low_bits_R8: assert property (@(posedge clk)
    (host_rdata_oe && host_addr[0]) |-> host_rdata[5:0] == 6'h3f);

  assert_load_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
    mcu_msg_load |=> host_irq);

  assert_cmd_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (mcu_cmd_ack && host_iow_n) |=> !mcu_cmd_pend);

  assert_data_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (mcu_data_ack && host_iow_n) |=> !mcu_data_pend);

  assert_irq_steady_without_events_R7: assert property (@(posedge clk) disable iff (rst)
    (!mcu_msg_load && host_ior_n) |=> $stable(host_irq));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!host_irq && !mcu_cmd_pend && !mcu_data_pend && !mcu_msg_pend));

endmodule

bind isa_midi_bridge isa_midi_bridge_chk chk (.*);

// File: tb/isa_midi_bridge_test.sv
module isa_midi_bridge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] jumper = 2'b11;
  logic [9:0] host_addr = 10'h000;
  logic       host_aen = 1'b0;
  logic       host_ior_n = 1'b1;
  logic       host_iow_n = 1'b1;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rdata_oe, host_irq;
  logic [7:0] mcu_cmd, mcu_data;
  logic       mcu_cmd_pend, mcu_data_pend, mcu_msg_pend;
  logic       mcu_cmd_ack = 1'b0, mcu_data_ack = 1'b0, mcu_msg_load = 1'b0;
  logic [7:0] mcu_msg = 8'h00;

  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  isa_midi_bridge uut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_iow_n = 1'b0;
    @(negedge clk); @(negedge clk);
    host_iow_n = 1'b1;
  endtask

  task automatic hread(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_ior_n = 1'b0;
    #1 d = host_rdata;
    @(negedge clk); @(negedge clk);
    host_ior_n = 1'b1;
  endtask

  task automatic ack_both();
    @(negedge clk); mcu_cmd_ack = 1'b1; mcu_data_ack = 1'b1;
    @(negedge clk); mcu_cmd_ack = 1'b0; mcu_data_ack = 1'b0;
  endtask

  task automatic load_msg(input logic [7:0] m);
    @(negedge clk); mcu_msg = m; mcu_msg_load = 1'b1;
    @(negedge clk); mcu_msg_load = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 irq after reset", host_irq, 0);
    check("R10 pends after reset", {mcu_cmd_pend, mcu_data_pend, mcu_msg_pend}, 0);
    check("R9 oe idle", host_rdata_oe, 0);
    hread(10'h331, rv);
    check("R8 idle status", rv, 8'hbf);
  endtask

  task automatic t_decode();
    hwrite(10'h330, 8'h11);
    @(negedge clk);
    check("R4 data pend", mcu_data_pend, 1);
    check("R4 data byte", mcu_data, 8'h11);
    ack_both();
    check("R5 data ack", mcu_data_pend, 0);
    hwrite(10'h320, 8'h22);
    hwrite(10'h338, 8'h23);
    hwrite(10'h130, 8'h24);
    hwrite(10'h370, 8'h25);
    @(negedge clk);
    check("R1 foreign addresses ignored", {mcu_cmd_pend, mcu_data_pend}, 0);
    check("R1 data byte kept", mcu_data, 8'h11);
    jumper = 2'b00;
    hwrite(10'h300, 8'h33);
    @(negedge clk);
    check("R1 jumper 00 window", {mcu_data_pend, mcu_data}, {8'h01, 8'h33});
    ack_both();
    jumper = 2'b11;
  endtask

  task automatic t_alias();
    hwrite(10'h337, 8'h44);
    @(negedge clk);
    check("R2 cmd via alias", {mcu_cmd_pend, mcu_cmd}, {8'h01, 8'h44});
    ack_both();
    load_msg(8'h66);
    hread(10'h336, rv);
    check("R2 data read via alias", rv, 8'h66);
    check("R7 irq cleared after alias read", host_irq, 0);
  endtask

  task automatic t_aen();
    host_aen = 1'b1;
    hwrite(10'h330, 8'h55);
    @(negedge clk);
    host_addr = 10'h331; host_ior_n = 1'b0;
    #1 check("R3 no oe with aen", host_rdata_oe, 0);
    @(negedge clk); host_ior_n = 1'b1;
    host_aen = 1'b0;
    check("R3 no capture with aen", {mcu_cmd_pend, mcu_data_pend}, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); host_addr = 10'h330; host_wdata = 8'ha1; host_iow_n = 1'b0;
    @(negedge clk); host_iow_n = 1'b1;
    @(negedge clk); host_addr = 10'h331; host_wdata = 8'hc2; host_iow_n = 1'b0;
    @(negedge clk); host_iow_n = 1'b1;
    @(negedge clk);
    check("R4 back-to-back data", {mcu_data_pend, mcu_data}, {8'h01, 8'ha1});
    check("R4 back-to-back cmd", {mcu_cmd_pend, mcu_cmd}, {8'h01, 8'hc2});
    hread(10'h331, rv);
    check("R8 busy status", rv, 8'hff);
    ack_both();
    hread(10'h331, rv);
    check("R8 ready status", rv, 8'hbf);
  endtask

  task automatic t_ack_collision();
    hwrite(10'h331, 8'h01);
    @(negedge clk);
    host_addr = 10'h331; host_wdata = 8'h02; host_iow_n = 1'b0; mcu_cmd_ack = 1'b1;
    @(negedge clk); mcu_cmd_ack = 1'b0;
    @(negedge clk); host_iow_n = 1'b1;
    check("R5 write beats ack", {mcu_cmd_pend, mcu_cmd}, {8'h01, 8'h02});
    @(negedge clk); mcu_cmd_ack = 1'b1;
    @(negedge clk); mcu_cmd_ack = 1'b0;
    check("R5 ack alone clears", mcu_cmd_pend, 0);
  endtask

  task automatic t_message();
    load_msg(8'h5a);
    check("R6 irq raised", {host_irq, mcu_msg_pend}, 2'b11);
    hread(10'h331, rv);
    check("R8 msg status", rv, 8'h3f);
    check("R6 status read keeps irq", host_irq, 1);
    hread(10'h330, rv);
    check("R7 read message", rv, 8'h5a);
    check("R7 irq dropped", {host_irq, mcu_msg_pend}, 0);
    load_msg(8'h70);
    @(negedge clk);
    host_addr = 10'h330; host_ior_n = 1'b0; mcu_msg = 8'h71; mcu_msg_load = 1'b1;
    #1 rv = host_rdata;
    @(negedge clk); mcu_msg_load = 1'b0;
    @(negedge clk); host_ior_n = 1'b1;
    check("R7 old byte during collision", rv, 8'h70);
    check("R7 load beats read", host_irq, 1);
    hread(10'h330, rv);
    check("R7 new byte kept", rv, 8'h71);
    check("R7 irq dropped again", host_irq, 0);
  endtask

  task automatic t_oe();
    @(negedge clk); host_addr = 10'h330;
    #1 check("R9 no oe without strobe", {host_rdata_oe, host_rdata}, 0);
    host_addr = 10'h334; host_ior_n = 1'b0;
    #1 check("R9 oe on decoded read", host_rdata_oe, 1);
    host_addr = 10'h230;
    #1 check("R9 no oe foreign read", {host_rdata_oe, host_rdata}, 0);
    @(negedge clk); host_ior_n = 1'b1;
  endtask

  task automatic t_midreset();
    hwrite(10'h330, 8'h01);
    hwrite(10'h331, 8'h02);
    load_msg(8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 mid reset clears", {host_irq, mcu_cmd_pend, mcu_data_pend, mcu_msg_pend}, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_alias();
    t_aen();
    t_back_to_back();
    t_ack_collision();
    t_message();
    t_oe();
    t_midreset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule